// File: doc/BRIEF.md
# Shared-Pin Parallel Port with Nibble Function Select

An eight-pin general-purpose port that sits on a plain memory-mapped byte bus. It has two registers. The direction register sets each pin as an input or an output. The data register holds the output latch and, when read, reports the pin levels. Each pin is shared with an alternate function. The upper four pins can carry debug trace bits and the lower four can carry processor status bits.

A two-bit function-select input works per nibble. It hands that nibble either to the port logic or to its alternate source. The block drives the pad output value and pad output enable. Pad inputs pass through a synchronizer before they reach the read path. Writes are single-cycle byte writes. Reads are combinational from the presented address.

Top module: `pport_mux`

## Requirements
- R1: After reset the direction register reads 0x00, the output latch is 0x00, and with both nibbles in port mode every output enable is low.
- R2: A write with `we_i` high at byte offset 0x1C5 loads the direction register on the next clock edge. A read at 0x1C5 returns its value.
- R3: With `we_i` low, or at an address other than 0x1C5 and 0x1C9, no register changes. A read at any other address returns 0x00.
- R4: In port mode a pin whose direction bit is 1 has its output enable high. On every port-mode pin, `pad_out_o` carries the latch bit.
- R5: In port mode a pin whose direction bit is 0 has its output enable low.
- R6: A read at offset 0x1C9 returns the synchronized pad level for port-mode input pins. A pad change becomes visible after exactly two rising clock edges, not after one.
- R7: A read at 0x1C9 returns the latch bit for port-mode output pins.
- R8: A write at 0x1C9 loads all eight latch bits, including those of input pins. Switching such a pin to output then shows the stored value at once.
- R9: `alt_sel_i[1]=1` drives `dbg_i[3:0]` onto pins 7..4 with their enables high. `alt_sel_i[0]=1` does the same for `stat_i[3:0]` on pins 3..0. In both cases the direction and latch bits of that nibble are ignored.
- R10: A read at 0x1C9 returns the alternate value that is being driven for pins in alternate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset from module base |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data for `addr_i` |
| alt_sel_i | input | 2 | Per-nibble function select, 1 = alternate (bit 1: pins 7..4) |
| dbg_i | input | 4 | Alternate source for pins 7..4 |
| stat_i | input | 4 | Alternate source for pins 3..0 |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad output enables |

## Verification
The bench builds the port with its defaults: four-pin groups, a two-stage synchronizer, and registers at 0x1C5 and 0x1C9. The two-stage depth lets the bench probe the first-edge and second-edge read of a pad change separately, so an extra or missing stage shows up as a wrong read. With two independent nibbles, each select bit can be toggled alone, showing that one nibble's alternate source never leaks into the other's direction or latch bits.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef enum logic {
    FN_PORT = 1'b0,
    FN_ALT  = 1'b1
  } pin_fn_e;

  typedef struct packed {
    logic dir;
    logic dat;
  } reg_hit_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int              W       = 8,
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS = 12'h1C5,
  parameter logic [ADDR_W-1:0] DAT_OFS = 12'h1C9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  output reg_hit_t          hit_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      lat_o
);
  always_comb begin
    hit_o.dir = (addr_i == DIR_OFS);
    hit_o.dat = (addr_i == DAT_OFS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      lat_o <= '0;
    end else if (we_i) begin
      if (hit_o.dir) dir_o <= wdata_i;
      // latch loads on all bits, direction irrelevant
      if (hit_o.dat) lat_o <= wdata_i;
    end
  end
endmodule

// File: rtl/pport_pinmux.sv
module pport_pinmux
  import pport_pkg::*;
#(
  parameter int GRP_W = 4,
  parameter int N_GRP = 2,
  localparam int W    = GRP_W * N_GRP
) (
  input  logic [N_GRP-1:0] alt_sel_i,
  input  logic [W-1:0]     alt_val_i,
  input  logic [W-1:0]     dir_i,
  input  logic [W-1:0]     lat_i,
  input  logic [W-1:0]     pin_sync_i,
  output logic [W-1:0]     pad_out_o,
  output logic [W-1:0]     pad_oe_o,
  output logic [W-1:0]     rd_dat_o
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    pin_fn_e fn;
    assign fn = pin_fn_e'(alt_sel_i[g]);

    always_comb begin
      if (fn == FN_ALT) begin
        pad_out_o[g*GRP_W +: GRP_W] = alt_val_i[g*GRP_W +: GRP_W];
        pad_oe_o [g*GRP_W +: GRP_W] = '1;
      end else begin
        pad_out_o[g*GRP_W +: GRP_W] = lat_i[g*GRP_W +: GRP_W];
        pad_oe_o [g*GRP_W +: GRP_W] = dir_i[g*GRP_W +: GRP_W];
      end
    end
  end

  // driven level where enabled, sampled level otherwise
  for (genvar b = 0; b < W; b++) begin : g_rd
    assign rd_dat_o[b] = pad_oe_o[b] ? pad_out_o[b] : pin_sync_i[b];
  end
endmodule

// File: rtl/pport_mux.sv
module pport_mux
  import pport_pkg::*;
#(
  parameter int                GRP_W       = 4,
  parameter int                ADDR_W      = 12,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_OFS     = 12'h1C5,
  parameter logic [ADDR_W-1:0] DAT_OFS     = 12'h1C9,
  localparam int               N_GRP       = 2,
  localparam int               W           = GRP_W * N_GRP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  output logic [W-1:0]      rdata_o,
  input  logic [N_GRP-1:0]  alt_sel_i,
  input  logic [GRP_W-1:0]  dbg_i,
  input  logic [GRP_W-1:0]  stat_i,
  input  logic [W-1:0]      pad_in_i,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_oe_o
);
  reg_hit_t       hit;
  logic [W-1:0]   dir_q;
  logic [W-1:0]   lat_q;
  logic [W-1:0]   pin_sync;
  logic [W-1:0]   rd_dat;

  pport_regs #(
    .W(W), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i,
    .hit_o(hit), .dir_o(dir_q), .lat_o(lat_q)
  );

  pport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pin_sync)
  );

  pport_pinmux #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_mux (
    .alt_sel_i,
    .alt_val_i ({dbg_i, stat_i}),
    .dir_i     (dir_q),
    .lat_i     (lat_q),
    .pin_sync_i(pin_sync),
    .pad_out_o,
    .pad_oe_o,
    .rd_dat_o  (rd_dat)
  );

  always_comb begin
    if (hit.dir)      rdata_o = dir_q;
    else if (hit.dat) rdata_o = rd_dat;
    else              rdata_o = '0;
  end
endmodule

// File: rtl/pport_mux_chk.sv
module pport_mux_chk #(
  parameter int                GRP_W   = 4,
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DIR_OFS = 12'h1C5,
  parameter logic [ADDR_W-1:0] DAT_OFS = 12'h1C9,
  localparam int               W       = GRP_W * 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic              we_i,
  input logic [W-1:0]      rdata_o,
  input logic [1:0]        alt_sel_i,
  input logic [GRP_W-1:0]  dbg_i,
  input logic [GRP_W-1:0]  stat_i,
  input logic [W-1:0]      pad_out_o,
  input logic [W-1:0]      pad_oe_o,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      lat_q
);
  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == DIR_OFS && alt_sel_i == 2'b00) |=>
      (alt_sel_i != 2'b00 || pad_oe_o == $past(wdata_i)));

  // R3
  no_we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(dir_q) && $stable(lat_q)));

  // R3
  miss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i != DIR_OFS && addr_i != DAT_OFS) |=>
      ($stable(dir_q) && $stable(lat_q)));

  // R5
  input_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alt_sel_i == 2'b00) |-> ((pad_oe_o & ~dir_q) == '0));

  // R9
  alt_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_sel_i[1] |-> (pad_oe_o[W-1:GRP_W] == '1 && pad_out_o[W-1:GRP_W] == dbg_i));

  // R9
  alt_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_sel_i[0] |-> (pad_oe_o[GRP_W-1:0] == '1 && pad_out_o[GRP_W-1:0] == stat_i));

  // R7 R10
  driven_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == DAT_OFS) |-> ((rdata_o & pad_oe_o) == (pad_out_o & pad_oe_o)));
endmodule

bind pport_mux pport_mux_chk #(
  .GRP_W(GRP_W), .ADDR_W(ADDR_W), .DIR_OFS(DIR_OFS), .DAT_OFS(DAT_OFS)
) u_chk (.*);

// File: tb/pport_mux_test.sv
`timescale 1ns/1ps
module pport_mux_test;
  localparam logic [11:0] A_DIR = 12'h1C5;
  localparam logic [11:0] A_DAT = 12'h1C9;
  localparam int K_RD = 0, K_OE = 1, K_OUT = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b1;
  logic [11:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [1:0]  alt_sel_i = 2'b00;
  logic [3:0]  dbg_i = '0;
  logic [3:0]  stat_i = '0;
  logic [7:0]  pad_in_i = 8'hA5;
  logic [7:0]  pad_out_o;
  logic [7:0]  pad_oe_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pport_mux uut (
    .clk_i(clk), .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .alt_sel_i, .dbg_i, .stat_i, .pad_in_i, .pad_out_o, .pad_oe_o
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb_q[$];
  item_t it_m;

  // monitor: pops expectations and samples at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      logic [7:0] act;
      it_m = sb_q.pop_front();
      case (it_m.kind)
        K_RD:    act = rdata_o;
        K_OE:    act = pad_oe_o;
        default: act = pad_out_o;
      endcase
      n_run++;
      if (act !== it_m.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it_m.tag, it_m.kind, act, it_m.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_rd(input logic [11:0] a, input logic [7:0] exp, input string tag);
    addr_i = a;
    push(K_RD, exp, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d, input logic we);
    addr_i = a; wdata_i = d; we_i = we;
    @(posedge clk); #1;
    we_i = 1'b0;
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk_rd(A_DIR, 8'h00, "R1");
    push(K_OE, 8'h00, "R1");
    push(K_OUT, 8'h00, "R1");
    chk_rd(A_DAT, 8'hA5, "R6");
    // R2 R4
    wr(A_DIR, 8'h3C, 1'b1);
    chk_rd(A_DIR, 8'h3C, "R2");
    push(K_OE, 8'h3C, "R4");
    // R7 mixed read
    wr(A_DAT, 8'hF0, 1'b1);
    chk_rd(A_DAT, 8'hB1, "R7");
    push(K_OUT, 8'hF0, "R4");
    // R3 writes ignored
    wr(A_DIR, 8'hFF, 1'b0);
    chk_rd(A_DIR, 8'h3C, "R3");
    wr(12'h1C6, 8'hFF, 1'b1);
    chk_rd(A_DIR, 8'h3C, "R3");
    push(K_OUT, 8'hF0, "R3");
    chk_rd(12'h1C6, 8'h00, "R3");
    // R8 latch loads on input pins
    wr(A_DIR, 8'h00, 1'b1);
    push(K_OE, 8'h00, "R5");
    wr(A_DAT, 8'h5A, 1'b1);
    push(K_OUT, 8'h5A, "R8");
    chk_rd(A_DAT, 8'hA5, "R8");
    wr(A_DIR, 8'hFF, 1'b1);
    chk_rd(A_DAT, 8'h5A, "R8");
    // R6 two-edge latency
    wr(A_DIR, 8'h00, 1'b1);
    pad_in_i = 8'h3C;
    chk_rd(A_DAT, 8'hA5, "R6");
    chk_rd(A_DAT, 8'hA5, "R6");
    chk_rd(A_DAT, 8'h3C, "R6");
    // R9 alternate nibbles
    wr(A_DIR, 8'h0F, 1'b1);
    wr(A_DAT, 8'h00, 1'b1);
    dbg_i = 4'h9; stat_i = 4'h6;
    alt_sel_i = 2'b10;
    push(K_OE, 8'hFF, "R9");
    push(K_OUT, 8'h90, "R9");
    chk_rd(A_DAT, 8'h90, "R10");
    alt_sel_i = 2'b01;
    push(K_OE, 8'h0F, "R9");
    push(K_OUT, 8'h06, "R9");
    chk_rd(A_DAT, 8'h36, "R10");
    wr(A_DIR, 8'h00, 1'b1);
    push(K_OE, 8'h0F, "R9");
    alt_sel_i = 2'b11;
    push(K_OUT, 8'h96, "R9");
    chk_rd(A_DAT, 8'h96, "R10");
    alt_sel_i = 2'b00;
    push(K_OE, 8'h00, "R5");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule